// File: doc/BRIEF.md
# Auxiliary Packet Status Flag Tracker

This block keeps two seven-bit flag vectors for the auxiliary packets that arrive on a video link: a sticky "seen" vector that records which packet kinds have been received at least once, and a "changed" vector that records which kinds have carried new content since software last looked. Upstream packet parsing delivers one strobe per packet kind together with a qualifier that says whether that packet's content differs from the previous one. A loss-of-clock indication from the link front end wipes the seen vector.

Software reads both vectors through a byte-wide read port with one cycle of latency. The seen vector sits at one fixed address. The changed vector is mirrored at every address whose low three bits are all ones inside the upper half of the 256-byte space, so a driver can poll it from whichever payload window it is walking. A read of any mirror returns the current changed vector and clears all of it at once. Reading the seen vector clears nothing.

Top module: `pft_flag_tracker`

## Requirements
- R1: Bit positions in both vectors, and in the strobe and qualifier inputs, are fixed: bit 0 video-format infoframe, bit 1 audio infoframe, bit 2 source-description infoframe, bit 3 MPEG source infoframe, bit 4 audio content-protection packet, bit 5 track-code packet 1, bit 6 track-code packet 2.
- R2: A strobe on `pkt_valid_i[i]` sets seen bit i at that clock edge, whatever the qualifier. The bit then stays set until reset or loss of clock.
- R3: `clk_lost_i` high at a clock edge clears the whole seen vector at that edge, and it wins over a strobe in the same cycle.
- R4: After reset both vectors are zero, so both the seen address and every mirror read 0x00, and `rd_valid_o` is low.
- R5: A strobe on `pkt_valid_i[i]` with `pkt_changed_i[i]` high sets changed bit i. A strobe with the qualifier low leaves changed bit i as it was.
- R6: A read with `rd_en_i` high is sampled at a clock edge. At that edge `rd_valid_o` goes high for one cycle and `rd_data_o` loads the result: the seen vector for address 0x10, the changed vector for any address in 0x80 to 0xFF whose bits [2:0] are 111, and 0x00 for every other address.
- R7: A read of any changed-vector mirror clears the whole changed vector at the edge where it is sampled. The data returned is the value from before the clear.
- R8: A changed strobe in the same cycle as a clearing read leaves its changed bit set after that edge.
- R9: A read of any address outside the mirror set leaves the changed vector untouched. This includes addresses below 0x80 whose low three bits are 111.
- R10: Bit 7 of `rd_data_o` is always 0.
- R11: Loss of clock has no effect on the changed vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_valid_i | input | 7 | One-cycle received strobe per packet kind |
| pkt_changed_i | input | 7 | Per-kind qualifier: content differs from the last packet |
| clk_lost_i | input | 1 | Link clock loss indication |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | 8 | Read address |
| rd_data_o | output | 8 | Registered read data |
| rd_valid_o | output | 1 | Read data valid, one cycle after the request |

## Verification
Flag updates from strobes, loss of clock and clearing reads all take effect at the same clock edge that samples them. Read data appears on the edge that samples the request, so it can be observed one cycle after the request is driven. The bench drives every input on the falling edge and samples `rd_data_o` on the next falling edge, which is half a period after the single register stage. A flag update is therefore confirmed by a read issued on the cycle after the stimulus. The race case drives a strobe and a clearing read in the same cycle, then checks both the pre-clear data and a second read.

// File: rtl/pft_pkg.sv
package pft_pkg;
  localparam int unsigned NUM_KINDS = 7;

  typedef enum logic [2:0] {
    KIND_VID_INFO = 3'd0,
    KIND_AUD_INFO = 3'd1,
    KIND_SRC_DESC = 3'd2,
    KIND_MPEG_SRC = 3'd3,
    KIND_CP       = 3'd4,
    KIND_TRK1     = 3'd5,
    KIND_TRK2     = 3'd6
  } pkt_kind_e;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_SEEN = 2'd1,
    SEL_CHG  = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/pft_sticky_vec.sv
module pft_sticky_vec #(
  parameter int unsigned W        = 7,
  parameter bit          SET_WINS = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] vec_o
);
  logic [W-1:0] q;

  for (genvar b = 0; b < int'(W); b++) begin : g_bit
    logic nxt;
    if (SET_WINS) begin : g_set_wins
      // event on the clearing edge must survive
      assign nxt = set_i[b] | (q[b] & ~clr_i);
    end else begin : g_clr_wins
      assign nxt = ~clr_i & (q[b] | set_i[b]);
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[b] <= 1'b0;
      else         q[b] <= nxt;
    end
  end

  assign vec_o = q;
endmodule

// File: rtl/pft_addr_decode.sv
module pft_addr_decode
  import pft_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned SEEN_ADR = 16,
  parameter int unsigned WIN_BASE = 128,
  parameter int unsigned WIN_SIZE = 128,
  parameter int unsigned LOW_W    = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  output rd_sel_e           sel_o
);
  localparam int unsigned WIN_END = WIN_BASE + WIN_SIZE;
  localparam logic [ADDR_W:0] BASE_X  = WIN_BASE[ADDR_W:0];
  localparam logic [ADDR_W:0] END_X   = WIN_END[ADDR_W:0];
  localparam logic [ADDR_W-1:0] SEEN_X = SEEN_ADR[ADDR_W-1:0];

  logic [ADDR_W:0] addr_x;
  logic            in_win;
  logic            low_ones;

  assign addr_x   = {1'b0, addr_i};
  assign in_win   = (addr_x >= BASE_X) && (addr_x < END_X);
  assign low_ones = &addr_i[LOW_W-1:0];

  always_comb begin
    if (addr_i == SEEN_X)        sel_o = SEL_SEEN;
    else if (in_win && low_ones) sel_o = SEL_CHG;
    else                         sel_o = SEL_NONE;
  end
endmodule

// File: rtl/pft_read_port.sv
module pft_read_port
  import pft_pkg::*;
#(
  parameter int unsigned N      = 7,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  rd_sel_e           sel_i,
  input  logic [N-1:0]      seen_i,
  input  logic [N-1:0]      chg_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  logic [DATA_W-1:0] data_d;

  always_comb begin
    data_d = '0;
    unique case (sel_i)
      SEL_SEEN: data_d[N-1:0] = seen_i;
      SEL_CHG:  data_d[N-1:0] = chg_i;
      default:  data_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= data_d;
    end
  end
endmodule

// File: rtl/pft_flag_tracker.sv
module pft_flag_tracker
  import pft_pkg::*;
#(
  parameter int unsigned N_KINDS  = NUM_KINDS,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SEEN_ADR = 16,
  parameter int unsigned WIN_BASE = 128,
  parameter int unsigned WIN_SIZE = 128,
  parameter int unsigned LOW_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_KINDS-1:0] pkt_valid_i,
  input  logic [N_KINDS-1:0] pkt_changed_i,
  input  logic              clk_lost_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  rd_sel_e              sel;
  logic [N_KINDS-1:0]   seen_vec;
  logic [N_KINDS-1:0]   chg_vec;
  logic [N_KINDS-1:0]   chg_set;
  logic                 chg_clr;

  assign chg_set = pkt_valid_i & pkt_changed_i;
  assign chg_clr = rd_en_i && (sel == SEL_CHG);

  pft_addr_decode #(
    .ADDR_W(ADDR_W), .SEEN_ADR(SEEN_ADR), .WIN_BASE(WIN_BASE),
    .WIN_SIZE(WIN_SIZE), .LOW_W(LOW_W)
  ) u_dec (
    .addr_i(rd_addr_i),
    .sel_o (sel)
  );

  // loss of clock dominates arrivals
  pft_sticky_vec #(.W(N_KINDS), .SET_WINS(1'b0)) u_seen (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (pkt_valid_i),
    .clr_i (clk_lost_i),
    .vec_o (seen_vec)
  );

  // a change on the clearing edge is kept
  pft_sticky_vec #(.W(N_KINDS), .SET_WINS(1'b1)) u_chg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (chg_set),
    .clr_i (chg_clr),
    .vec_o (chg_vec)
  );

  pft_read_port #(.N(N_KINDS), .DATA_W(DATA_W)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (rd_en_i),
    .sel_i     (sel),
    .seen_i    (seen_vec),
    .chg_i     (chg_vec),
    .rd_data_o (rd_data_o),
    .rd_valid_o(rd_valid_o)
  );
endmodule

// File: rtl/pft_flag_tracker_chk.sv
module pft_flag_tracker_chk #(
  parameter int unsigned N      = 7,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N-1:0]      pkt_valid_i,
  input logic [N-1:0]      pkt_changed_i,
  input logic              clk_lost_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rd_valid_o,
  input logic [N-1:0]      seen_vec,
  input logic [N-1:0]      chg_vec
);
  logic              mirror_rd;
  logic [N-1:0]      evt;
  logic [DATA_W-1:0] chg_ext;

  always_comb begin
    mirror_rd = rd_en_i && rd_addr_i[ADDR_W-1] && (rd_addr_i[2:0] == 3'b111);
    evt       = pkt_valid_i & pkt_changed_i;
    chg_ext   = '0;
    chg_ext[N-1:0] = chg_vec;
  end

  assert_seen_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pkt_valid_i != '0) && !clk_lost_i) |=> ((seen_vec & $past(pkt_valid_i)) == $past(pkt_valid_i)));

  assert_seen_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_lost_i |=> ((seen_vec & $past(seen_vec)) == $past(seen_vec)));

  assert_loss_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_lost_i |=> (seen_vec == '0));

  assert_chg_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt != '0) |=> ((chg_vec & $past(evt)) == $past(evt)));

  assert_chg_only_on_change_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((chg_vec & ~$past(chg_vec) & ~$past(evt)) == '0));

  assert_chg_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mirror_rd && (evt == '0)) |=> (chg_vec == '0));

  assert_chg_rd_preclear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mirror_rd |=> (rd_data_o == $past(chg_ext)));

  assert_chg_keep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mirror_rd |=> ((chg_vec & $past(chg_vec)) == $past(chg_vec)));

  assert_rd_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);

  assert_rd_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o);

  assert_msb_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> ((rd_data_o >> N) == '0));
endmodule

bind pft_flag_tracker pft_flag_tracker_chk #(
  .N(N_KINDS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pkt_valid_i  (pkt_valid_i),
  .pkt_changed_i(pkt_changed_i),
  .clk_lost_i   (clk_lost_i),
  .rd_en_i      (rd_en_i),
  .rd_addr_i    (rd_addr_i),
  .rd_data_o    (rd_data_o),
  .rd_valid_o   (rd_valid_o),
  .seen_vec     (seen_vec),
  .chg_vec      (chg_vec)
);

// File: tb/pft_flag_tracker_tb.sv
`timescale 1ns/1ps
module pft_flag_tracker_tb_top;
  localparam logic [7:0] SEEN_A = 8'h10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] pkt_valid_i = '0;
  logic [6:0] pkt_changed_i = '0;
  logic       clk_lost_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [7:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic       rd_valid_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  pft_flag_tracker dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pkt_valid_i(pkt_valid_i),
    .pkt_changed_i(pkt_changed_i), .clk_lost_i(clk_lost_i),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    rd_en_i = 1'b1; rd_addr_i = a;
    @(negedge clk_i);
    d = rd_data_o;
    rd_en_i = 1'b0;
  endtask

  task automatic strobe(input logic [6:0] v, input logic [6:0] c);
    pkt_valid_i = v; pkt_changed_i = c;
    @(negedge clk_i);
    pkt_valid_i = '0; pkt_changed_i = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R4 rd_valid after reset", {7'b0, rd_valid_o}, 8'h00);
    rd(SEEN_A, d); chk("R4 seen after reset", d, 8'h00);
    rd(8'h87, d);  chk("R4 changed after reset", d, 8'h00);
  endtask

  task automatic t_detect();
    logic [7:0] d;
    strobe(7'h01, 7'h00);
    rd(SEEN_A, d); chk("R2 R1 seen bit0", d, 8'h01);
    chk("R6 rd_valid high", {7'b0, rd_valid_o}, 8'h01);
    @(negedge clk_i);
    chk("R6 rd_valid drops", {7'b0, rd_valid_o}, 8'h00);
    rd(8'h87, d);  chk("R5 unchanged strobe no changed bit", d, 8'h00);
    strobe(7'h44, 7'h00);
    rd(SEEN_A, d); chk("R1 seen bits 2 and 6", d, 8'h45);
    repeat (5) @(negedge clk_i);
    rd(SEEN_A, d); chk("R2 seen sticky", d, 8'h45);
  endtask

  task automatic t_newdata();
    logic [7:0] d;
    strobe(7'h02, 7'h02);
    rd(8'h8F, d); chk("R5 changed bit1", d, 8'h02);
    rd(8'hFF, d); chk("R7 cleared by read", d, 8'h00);
  endtask

  task automatic t_mirror();
    logic [7:0] d;
    for (int a = 8'h87; a <= 8'hFF; a += 8) begin
      strobe(7'h7F, 7'h7F);
      rd(8'(a), d); chk($sformatf("R6 R10 mirror 0x%02h", a), d, 8'h7F);
    end
    rd(8'hB7, d); chk("R7 all mirrors cleared", d, 8'h00);
  endtask

  task automatic t_non_mirror();
    logic [7:0] d;
    strobe(7'h30, 7'h30);
    rd(8'h07, d); chk("R6 R9 addr 0x07", d, 8'h00);
    rd(8'h7F, d); chk("R6 R9 addr 0x7F", d, 8'h00);
    rd(8'h86, d); chk("R6 R9 addr 0x86", d, 8'h00);
    rd(8'h88, d); chk("R6 R9 addr 0x88", d, 8'h00);
    rd(SEEN_A, d); chk("R6 seen address", d, 8'h7F);
    rd(8'h97, d); chk("R9 changed untouched", d, 8'h30);
  endtask

  task automatic t_race();
    logic [7:0] d;
    strobe(7'h01, 7'h01);
    pkt_valid_i = 7'h09; pkt_changed_i = 7'h09;
    rd(8'hC7, d);
    pkt_valid_i = '0; pkt_changed_i = '0;
    chk("R7 pre-clear data", d, 8'h01);
    rd(8'hC7, d); chk("R8 strobe on clearing edge kept", d, 8'h09);
    rd(8'hC7, d); chk("R7 cleared after", d, 8'h00);
  endtask

  task automatic t_clk_loss();
    logic [7:0] d;
    strobe(7'h04, 7'h04);
    clk_lost_i = 1'b1; @(negedge clk_i); clk_lost_i = 1'b0;
    rd(SEEN_A, d); chk("R3 seen cleared by loss", d, 8'h00);
    rd(8'hE7, d);  chk("R11 changed kept over loss", d, 8'h04);
    clk_lost_i = 1'b1;
    strobe(7'h20, 7'h20);
    clk_lost_i = 1'b0;
    rd(SEEN_A, d); chk("R3 loss wins over strobe", d, 8'h00);
    strobe(7'h20, 7'h00);
    rd(SEEN_A, d); chk("R2 seen after loss", d, 8'h20);
    rd(8'hEF, d);  chk("R11 changed set during loss", d, 8'h20);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_detect();
    t_newdata();
    t_mirror();
    t_non_mirror();
    t_race();
    t_clk_loss();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule